// File: doc/BRIEF.md
# Disk Write Precompensation Shifter

This block sits on the write-data path to a floppy drive and shifts each write pulse by a fixed precompensation interval. The pulse can leave early, on time or late. A rising edge on the write-data input arms a strobe, which starts a sequencer of four equal phases. The outgoing pulse then fills one whole phase, and the early/late request picks which phase that is. The request is sampled at the same clock edge that arms the strobe.

The phase width is the parameter `PHASE_CYC`, counted in system clock cycles. For example, 4 cycles at 20 MHz gives a 200 ns shift. The strobe clears as phase 4 begins, so a new pulse may arrive during phase 4 and restart the sequence. A pulse that arrives during phases 1 to 3 is dropped and raises an error flag for one cycle.

On outer tracks, or when single density is selected, the shifter is bypassed. In that case the write-data input is copied straight to the output.

Top module: `wpc_shifter`

## Requirements
- R1: When not bypassed and idle, a rising edge of `wr_in` sampled at clock edge T starts four phases, numbered 1 to 4. Phase n holds for the `PHASE_CYC` cycles that follow edges T+(n-1)·PHASE_CYC through T+n·PHASE_CYC-1.
- R2: With `early_i`=0 and `late_i`=0, `wr_out` is 1 exactly throughout phase 2 and 0 for the rest of the sequence.
- R3: With `early_i`=1 and `late_i`=0, `wr_out` is 1 exactly throughout phase 1.
- R4: With `early_i`=0 and `late_i`=1, `wr_out` is 1 exactly throughout phase 3.
- R5: With `early_i`=1 and `late_i`=1, the request is treated as nominal and `wr_out` is 1 throughout phase 2.
- R6: `early_i` and `late_i` are sampled only at edge T. Changing them during a sequence does not move the pulse.
- R7: While `inner_trk`=0 or `single_den`=1, `wr_out` equals `wr_in` in the same cycle and no sequence starts. A pulse seen in this mode does not produce a shifted pulse afterwards.
- R8: A rising edge of `wr_in` during phases 1 to 3 is ignored, and `overlap_err` is 1 for exactly the one cycle after that edge. A rising edge during phase 4 is accepted and restarts the sequence without raising `overlap_err`.
- R9: After reset, `wr_out` and `overlap_err` are 0 and the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_in | input | 1 | Write-data input; a rising edge marks a pulse |
| early_i | input | 1 | Request to shift the pulse early |
| late_i | input | 1 | Request to shift the pulse late |
| inner_trk | input | 1 | 1 when writing an inner track (precompensation zone) |
| single_den | input | 1 | 1 selects single density (forces bypass) |
| wr_out | output | 1 | Precompensated write-data output |
| overlap_err | output | 1 | One-cycle flag for a pulse dropped mid-sequence |

## Verification
The assertions assume that `wr_in` pulses are separated by at least one low cycle, so that two rising edges are never seen on adjacent clock edges. This is what allows the error flag to be checked as a single-cycle pulse. The bench drives every input on the falling clock edge. It raises each write pulse for exactly one cycle and never raises a second one until `wr_in` has been low for at least one cycle. Mode inputs are changed only while the sequencer is idle, except in the test that deliberately changes the early/late request during a sequence.

// File: rtl/wpc_shifter.sv
module wpc_shifter #(
  parameter int PHASE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_in,
  input  logic early_i,
  input  logic late_i,
  input  logic inner_trk,
  input  logic single_den,
  output logic wr_out,
  output logic overlap_err
);
  localparam int CW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(PHASE_CYC - 1);

  logic          wr_q, active;
  logic [1:0]    phase, sel;
  logic [CW-1:0] cnt;

  wire bypass   = !inner_trk || single_den;
  wire rise     = wr_in && !wr_q;
  wire busy     = active && (phase != 2'd3);
  wire start    = rise && !bypass && !busy;
  wire [1:0] sel_next = (early_i ^ late_i) ? (early_i ? 2'd0 : 2'd2) : 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_q        <= 1'b0;
      active      <= 1'b0;
      phase       <= 2'd0;
      sel         <= 2'd1;
      cnt         <= '0;
      overlap_err <= 1'b0;
    end else begin
      wr_q        <= wr_in;
      overlap_err <= rise && !bypass && busy;
      if (start) begin
        active <= 1'b1;
        phase  <= 2'd0;
        cnt    <= '0;
        sel    <= sel_next;
      end else if (active) begin
        if (cnt == CNT_LAST) begin
          cnt <= '0;
          if (phase == 2'd3) active <= 1'b0;
          else               phase  <= phase + 2'd1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign wr_out = bypass ? wr_in : (active && phase == sel);
endmodule

module wpc_shifter_chk #(
  parameter int PHASE_CYC = 4,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_in,
  input logic          inner_trk,
  input logic          single_den,
  input logic          wr_out,
  input logic          overlap_err,
  input logic          active,
  input logic [1:0]    phase,
  input logic [CW-1:0] cnt
);
  wire prec = inner_trk && !single_den;

  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) < PHASE_CYC);

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (active && int'(cnt) == PHASE_CYC - 1 && phase != 2'd3) |=> (phase == $past(phase) + 2'd1));

  assert_out_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (prec && wr_out) |-> (active && phase != 2'd3));

  assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |=> !overlap_err);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overlap_err |-> ($past(wr_in) && $past(active) && $past(phase) != 2'd3));

  assert_idle_reset_R9: assert property (@(posedge clk)
    $past(!rst_n) |-> (!active && !overlap_err));
endmodule

bind wpc_shifter wpc_shifter_chk #(.PHASE_CYC(PHASE_CYC), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_in(wr_in), .inner_trk(inner_trk),
  .single_den(single_den), .wr_out(wr_out), .overlap_err(overlap_err),
  .active(active), .phase(phase), .cnt(cnt)
);

// File: tb/tb_wpc_shifter.sv
`timescale 1ns/1ps
module tb_wpc_shifter;
  localparam int P = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_in = 0, early_i = 0, late_i = 0, inner_trk = 1, single_den = 0;
  logic wr_out, overlap_err;
  int checks = 0, failures = 0;

  wpc_shifter #(.PHASE_CYC(P)) dut (
    .clk(clk), .rst_n(rst_n), .wr_in(wr_in), .early_i(early_i), .late_i(late_i),
    .inner_trk(inner_trk), .single_den(single_den),
    .wr_out(wr_out), .overlap_err(overlap_err));

  always #2.5 clk = ~clk;

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // wr_in was raised at the current negedge; sample k = 1..stop_k negedges.
  // inj_k > 0 raises a second pulse after sampling at that negedge.
  task automatic run_seq(input int sel, input int inj_k, input int stop_k,
                         input logic flip, input string tag);
    for (int k = 1; k <= stop_k; k++) begin
      @(negedge clk);
      chk(wr_out, (k <= 4*P) && ((k-1)/P == sel), tag);
      if (inj_k > 0 && k == inj_k + 1)
        chk(overlap_err, ((inj_k)/P) < 3, "R8");
      else
        chk(overlap_err, 1'b0, "R8");
      if (k == 1 && flip) begin
        early_i = ~early_i;
        late_i  = ~late_i;
      end
      wr_in = (inj_k > 0 && k == inj_k);
    end
  endtask

  function automatic int exp_sel(input logic e, input logic l);
    if (e && !l) return 0;
    if (l && !e) return 2;
    return 1;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_out, 1'b0, "R9");
    chk(overlap_err, 1'b0, "R9");
    rst_n = 1'b1;
    @(negedge clk);
    chk(wr_out, 1'b0, "R9");

    for (int f = 0; f < 2; f++)
      for (int c = 0; c < 4; c++) begin
        logic e, l;
        e = c[0]; l = c[1];
        early_i = e; late_i = l; wr_in = 1;
        run_seq(exp_sel(e, l), 0, 4*P + 2, f == 1,
                f == 1 ? "R6" : (!e && !l) ? "R2" : (e && !l) ? "R3" : (l && !e) ? "R4" : "R5");
      end

    // pulse during phases 2 and 3 ignored, error for one cycle
    for (int inj = P + 1; inj <= 3*P - 1; inj += P - 1) begin
      early_i = 0; late_i = 0; wr_in = 1;
      run_seq(1, inj, 4*P + 2, 1'b0, "R8");
    end

    // pulse during phase 4 restarts the sequence
    early_i = 1; late_i = 0; wr_in = 1;
    run_seq(0, 0, 3*P + 1, 1'b0, "R8");
    early_i = 0; late_i = 1; wr_in = 1;
    run_seq(2, 0, 4*P + 2, 1'b0, "R8");

    // bypass modes
    for (int m = 0; m < 2; m++) begin
      inner_trk = (m == 1); single_den = (m == 1);
      early_i = 1; late_i = 0;
      wr_in = 1; #1;
      chk(wr_out, 1'b1, "R7");
      @(negedge clk);
      chk(wr_out, 1'b1, "R7");
      wr_in = 0; #1;
      chk(wr_out, 1'b0, "R7");
      inner_trk = 1; single_den = 0;
      for (int k = 0; k < 4*P + 1; k++) begin
        @(negedge clk);
        chk(wr_out, 1'b0, "R7");
        chk(overlap_err, 1'b0, "R7");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    failures++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule